// File: doc/BRIEF.md
# Instrument Status Reporting Register Unit

This block gathers the status of a programmable instrument into two host-visible bytes and raises a service request when an enabled condition appears. Single-cycle event pulses from the command and execution logic set sticky bits in a standard event register. These events cover query error, device error, execution error, command error and user request, and operation complete also lands there. Power-on is set out of reset. Level inputs are folded together into a status byte: error queue pending, output message available, and the operation and questionable summaries from neighbouring register groups.

The host writes two enable masks through a small register port. The first mask selects which event bits feed the event summary bit of the status byte. The second selects which status-byte bits may raise a service request. Reading the event register is destructive. Reading the status byte is not. A serial-poll acknowledge clears the pending service request.

Top module: `instr_status_unit`

## Requirements
- R1: Out of reset the event register holds 0x80 (power-on only), both enable masks are zero, `srq` is low and `rd_data` is zero.
- R2: A status-byte read returns, one cycle later on `rd_data`, bit 7 = `oper_summary`, bit 6 = pending service request, bit 5 = event summary, bit 4 = `out_msg_avail`, bit 3 = `ques_summary`, bit 2 = `err_queue_nonempty`, and bits 1 and 0 = 0.
- R3: Event pulses set sticky event-register bits at these positions: `ev_user_req` bit 6, `ev_cmd_err` bit 5, `ev_exec_err` bit 4, `ev_dev_err` bit 3, `ev_query_err` bit 2. Bit 1 always reads 0.
- R4: An event-register read (`rd_esr_en`) returns the register on `rd_data` one cycle later and clears every bit. An event pulsed in the same cycle as the read stays set afterwards. If both reads are requested together, the event-register read wins.
- R5: Bit 0 of the event register is set only when `ops_idle` is high while an operation-complete arm (`opc_arm` pulse seen earlier) is pending. The arm is dropped once the bit is set, so `ops_idle` alone sets nothing.
- R6: Status-byte bit 5 is high exactly when some event-register bit and its matching event-enable mask bit (`wr_sel`=0) are both high.
- R7: The service-request condition is the OR of status-byte bits 7, 5, 4, 3 and 2, each ANDed with the service-request mask (`wr_sel`=1). Mask bit 6 is ignored. `srq` and status-byte bit 6 rise one cycle after the condition rises.
- R8: `poll_ack` clears `srq`, and it stays low while the condition remains high. A status-byte read does not clear `srq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_query_err | input | 1 | Query error pulse |
| ev_dev_err | input | 1 | Device error pulse |
| ev_exec_err | input | 1 | Execution error pulse |
| ev_cmd_err | input | 1 | Command error pulse |
| ev_user_req | input | 1 | User request pulse |
| opc_arm | input | 1 | Operation-complete command seen, arms bit 0 |
| ops_idle | input | 1 | High when no operation is pending |
| err_queue_nonempty | input | 1 | Error queue holds an unread code |
| out_msg_avail | input | 1 | Output queue holds data |
| oper_summary | input | 1 | Operation group summary |
| ques_summary | input | 1 | Questionable group summary |
| wr_en | input | 1 | Mask write strobe |
| wr_sel | input | 1 | 0 = event-enable mask, 1 = service-request mask |
| wr_data | input | 8 | Mask write value |
| rd_stb_en | input | 1 | Status-byte read request |
| rd_esr_en | input | 1 | Destructive event-register read request |
| poll_ack | input | 1 | Serial-poll acknowledge |
| rd_data | output | 8 | Registered read result |
| srq | output | 1 | Service request |

## Verification
A stuck or lost event bit appears in the next event-register read as a wrong byte, one cycle after the read strobe. A wrong clear shows in the read that follows it. A faulty enable mask or summary path shows in a status-byte read issued in the same cycle as the fault. A wrong edge detector or acknowledge path shows on `srq` within one or two cycles: it rises when it should not, fails to rise, or rises again while the condition merely stays high.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int STB_W = 8;
  localparam int NUM_MASK = 2;
  typedef logic [STB_W-1:0] byte_t;

  localparam int B_OPC = 0;
  localparam int B_QYE = 2;
  localparam int B_DDE = 3;
  localparam int B_EXE = 4;
  localparam int B_CME = 5;
  localparam int B_URQ = 6;
  localparam int B_PON = 7;

  localparam byte_t ESR_RESET    = byte_t'(1) << B_PON;
  localparam byte_t ESR_LIVE     = ~(byte_t'(1) << 1);
  localparam byte_t SRQ_SRC_MASK = 8'hBC;

  function automatic byte_t f_stb(input logic oper, input logic rqs,
                                  input logic esb, input logic mav,
                                  input logic ques, input logic eeq);
    return {oper, rqs, esb, mav, ques, eeq, 2'b00};
  endfunction

  function automatic logic f_srq_cond(input byte_t stb, input byte_t sre);
    return |(stb & sre & SRQ_SRC_MASK);
  endfunction
endpackage

// File: rtl/isu_event_reg.sv
module isu_event_reg
  import isu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t ev_set,
  input  logic  opc_arm,
  input  logic  ops_idle,
  input  logic  clr,
  output byte_t esr_q,
  output logic  arm_q,
  output logic  opc_set_w
);
  byte_t kept;

  assign opc_set_w = arm_q & ops_idle;
  assign kept      = clr ? '0 : esr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      esr_q <= ESR_RESET;
      arm_q <= 1'b0;
    end else begin
      esr_q <= (kept | ev_set | (byte_t'(opc_set_w) << B_OPC)) & ESR_LIVE;
      arm_q <= opc_arm | (arm_q & ~ops_idle);
    end
  end
endmodule

// File: rtl/isu_mask_bank.sv
module isu_mask_bank
  import isu_pkg::*;
#(
  parameter int N = NUM_MASK,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SW-1:0]             wr_sel,
  input  byte_t                     wr_data,
  output logic [N-1:0][STB_W-1:0]   masks
);
  for (genvar g = 0; g < N; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n) masks[g] <= '0;
      else if (wr_en && (wr_sel == SW'(g))) masks[g] <= wr_data;
    end
  end
endmodule

// File: rtl/isu_srq_ctrl.sv
module isu_srq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic poll_ack,
  output logic rqs_q,
  output logic rise_w
);
  logic cond_q;

  assign rise_w = cond & ~cond_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      rqs_q  <= 1'b0;
    end else begin
      cond_q <= cond;
      if (rise_w)        rqs_q <= 1'b1;
      else if (poll_ack) rqs_q <= 1'b0;
    end
  end
endmodule

// File: rtl/instr_status_unit.sv
module instr_status_unit
  import isu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_query_err,
  input  logic       ev_dev_err,
  input  logic       ev_exec_err,
  input  logic       ev_cmd_err,
  input  logic       ev_user_req,
  input  logic       opc_arm,
  input  logic       ops_idle,
  input  logic       err_queue_nonempty,
  input  logic       out_msg_avail,
  input  logic       oper_summary,
  input  logic       ques_summary,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_stb_en,
  input  logic       rd_esr_en,
  input  logic       poll_ack,
  output logic [7:0] rd_data,
  output logic       srq
);
  byte_t ev_vec, esr_q, ese_q, sre_q, stb_w;
  logic  arm_q, opc_set_w, esb_w, cond_w, rise_w, rqs_q, ev_any_w;
  logic [NUM_MASK-1:0][STB_W-1:0] masks;

  always_comb begin
    ev_vec        = '0;
    ev_vec[B_QYE] = ev_query_err;
    ev_vec[B_DDE] = ev_dev_err;
    ev_vec[B_EXE] = ev_exec_err;
    ev_vec[B_CME] = ev_cmd_err;
    ev_vec[B_URQ] = ev_user_req;
  end
  assign ev_any_w = |ev_vec;

  isu_event_reg u_esr (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_vec), .opc_arm(opc_arm),
    .ops_idle(ops_idle), .clr(rd_esr_en), .esr_q(esr_q), .arm_q(arm_q),
    .opc_set_w(opc_set_w)
  );

  isu_mask_bank #(.N(NUM_MASK)) u_masks (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .masks(masks)
  );
  assign ese_q = masks[0];
  assign sre_q = masks[1];

  assign esb_w  = |(esr_q & ese_q);
  assign stb_w  = f_stb(oper_summary, rqs_q, esb_w, out_msg_avail,
                        ques_summary, err_queue_nonempty);
  assign cond_w = f_srq_cond(stb_w, sre_q);

  isu_srq_ctrl u_srq (
    .clk(clk), .rst_n(rst_n), .cond(cond_w), .poll_ack(poll_ack),
    .rqs_q(rqs_q), .rise_w(rise_w)
  );
  assign srq = rqs_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         rd_data <= '0;
    else if (rd_esr_en) rd_data <= esr_q;
    else if (rd_stb_en) rd_data <= stb_w;
  end
endmodule

// File: rtl/isu_chk.sv
module isu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_esr_en,
  input logic       rd_stb_en,
  input logic       poll_ack,
  input logic       ev_any,
  input logic [7:0] esr_q,
  input logic       arm_q,
  input logic       cond,
  input logic       rise,
  input logic       srq,
  input logic [7:0] rd_data
);
  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_en && !rd_esr_en) |=> (rd_data[1:0] == 2'b00));

  a_r3_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_esr_en |=> ((esr_q & $past(esr_q)) == $past(esr_q)));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_esr_en && !ev_any) |=> (esr_q[7:2] == 6'd0));

  a_r5_opc_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(esr_q[0]) |-> $past(arm_q));

  a_r7_srq_from_cond: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srq) |-> $past(cond));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_ack && !rise) |=> !srq);
endmodule

bind instr_status_unit isu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_esr_en(rd_esr_en), .rd_stb_en(rd_stb_en),
  .poll_ack(poll_ack), .ev_any(ev_any_w), .esr_q(esr_q), .arm_q(arm_q),
  .cond(cond_w), .rise(rise_w), .srq(srq), .rd_data(rd_data)
);

// File: tb/sim_instr_status_unit.sv
`timescale 1ns/1ps
module sim_instr_status_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_query_err = 0, ev_dev_err = 0, ev_exec_err = 0, ev_cmd_err = 0;
  logic ev_user_req = 0, opc_arm = 0, ops_idle = 0;
  logic err_queue_nonempty = 0, out_msg_avail = 0, oper_summary = 0, ques_summary = 0;
  logic wr_en = 0, wr_sel = 0, rd_stb_en = 0, rd_esr_en = 0, poll_ack = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic srq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  instr_status_unit u0 (.*);

  // levels {oper, ques, eeq, mav} -> expected status byte (R2)
  localparam logic [11:0] STB_VEC [6] = '{
    {4'b0000, 8'h00}, {4'b1000, 8'h80}, {4'b0100, 8'h08},
    {4'b0010, 8'h04}, {4'b0001, 8'h10}, {4'b1111, 8'h9C}
  };
  // event index -> expected event register after one pulse (R3)
  localparam logic [10:0] EV_VEC [5] = '{
    {3'd0, 8'h04}, {3'd1, 8'h08}, {3'd2, 8'h10}, {3'd3, 8'h20}, {3'd4, 8'h40}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd_esr(output logic [7:0] v);
    @(negedge clk) rd_esr_en = 1;
    @(negedge clk) rd_esr_en = 0;
    v = rd_data;
  endtask

  task automatic rd_stb(output logic [7:0] v);
    @(negedge clk) rd_stb_en = 1;
    @(negedge clk) rd_stb_en = 0;
    v = rd_data;
  endtask

  task automatic wr_mask(input logic sel, input logic [7:0] d);
    @(negedge clk) begin wr_en = 1; wr_sel = sel; wr_data = d; end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic set_ev(input int idx, input logic v);
    case (idx)
      0: ev_query_err = v;
      1: ev_dev_err   = v;
      2: ev_exec_err  = v;
      3: ev_cmd_err   = v;
      default: ev_user_req = v;
    endcase
  endtask

  task automatic pulse_ev(input int idx);
    @(negedge clk) set_ev(idx, 1);
    @(negedge clk) set_ev(idx, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    cyc(3);
    @(negedge clk) rst_n = 1;
    check("R1 srq after reset", {7'd0, srq}, 8'h00);
    check("R1 rd_data after reset", rd_data, 8'h00);
    rd_stb(v); check("R1 status byte, masks zero", v, 8'h00);
    rd_esr(v); check("R1 power-on bit", v, 8'h80);
    rd_esr(v); check("R4 cleared after read", v, 8'h00);

    for (int i = 0; i < 6; i++) begin
      @(negedge clk) {oper_summary, ques_summary, err_queue_nonempty, out_msg_avail} = STB_VEC[i][11:8];
      rd_stb(v); check($sformatf("R2 vector %0d", i), v, STB_VEC[i][7:0]);
    end
    @(negedge clk) {oper_summary, ques_summary, err_queue_nonempty, out_msg_avail} = 4'b0000;

    for (int i = 0; i < 5; i++) begin
      pulse_ev(int'(EV_VEC[i][10:8]));
      cyc(2);
      rd_esr(v); check($sformatf("R3 event %0d sticky", i), v, EV_VEC[i][7:0]);
    end

    pulse_ev(0); pulse_ev(3);
    rd_stb(v); check("R4 status read not destructive", v, 8'h00);
    rd_esr(v); check("R3 two events combine", v, 8'h24);
    @(negedge clk) begin rd_esr_en = 1; ev_cmd_err = 1; end
    @(negedge clk) begin rd_esr_en = 0; ev_cmd_err = 0; end
    check("R4 read returns old value", rd_data, 8'h00);
    rd_esr(v); check("R4 same-cycle event kept", v, 8'h20);
    @(negedge clk) begin rd_esr_en = 1; rd_stb_en = 1; ev_dev_err = 1; end
    @(negedge clk) begin rd_esr_en = 0; rd_stb_en = 0; ev_dev_err = 0; end
    check("R4 event read wins over status read", rd_data, 8'h00);
    rd_esr(v); check("R4 event kept on dual read", v, 8'h08);

    @(negedge clk) ops_idle = 1;
    cyc(2);
    rd_esr(v); check("R5 idle without arm", v, 8'h00);
    @(negedge clk) begin ops_idle = 0; opc_arm = 1; end
    @(negedge clk) opc_arm = 0;
    cyc(3);
    rd_esr(v); check("R5 armed but busy", v, 8'h00);
    @(negedge clk) ops_idle = 1;
    @(negedge clk);
    rd_esr(v); check("R5 operation complete set", v, 8'h01);
    cyc(2);
    rd_esr(v); check("R5 arm dropped after set", v, 8'h00);
    @(negedge clk) ops_idle = 0;

    wr_mask(0, 8'h20);
    pulse_ev(3);
    rd_stb(v); check("R6 summary on enabled bit", v, 8'h20);
    wr_mask(0, 8'h10);
    rd_stb(v); check("R6 summary masked", v, 8'h00);
    check("R7 no srq with zero mask", {7'd0, srq}, 8'h00);
    rd_esr(v);

    wr_mask(0, 8'h20); wr_mask(1, 8'h20);
    @(negedge clk) ev_cmd_err = 1;
    @(negedge clk) ev_cmd_err = 0;
    check("R7 srq not yet", {7'd0, srq}, 8'h00);
    @(negedge clk);
    check("R7 srq one cycle after condition", {7'd0, srq}, 8'h01);
    rd_stb(v); check("R8 status read shows request", v, 8'h60);
    check("R8 status read keeps srq", {7'd0, srq}, 8'h01);
    @(negedge clk) poll_ack = 1;
    @(negedge clk) poll_ack = 0;
    check("R8 poll ack clears", {7'd0, srq}, 8'h00);
    cyc(3);
    check("R8 no re-raise on steady condition", {7'd0, srq}, 8'h00);
    rd_esr(v);

    wr_mask(0, 8'hFF); wr_mask(1, 8'h40);
    pulse_ev(4);
    cyc(3);
    check("R7 mask bit 6 ignored", {7'd0, srq}, 8'h00);
    rd_esr(v);
    wr_mask(1, 8'h10);
    @(negedge clk) out_msg_avail = 1;
    cyc(2);
    check("R7 message-available request", {7'd0, srq}, 8'h01);
    @(negedge clk) begin poll_ack = 1; out_msg_avail = 0; end
    @(negedge clk) poll_ack = 0;
    check("R8 cleared after ack", {7'd0, srq}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule